// File: doc/BRIEF.md
# SPI Slave Receiver with Unread-Data Timeout

This block is the receive half of an SPI slave. An external master drives the serial clock, an active-low select and the data line. The block samples all three with its own faster system clock, rebuilds 16-bit words, and queues them in an eight-entry FIFO. A host drains the FIFO through a valid/ready read port. Back-pressure works as follows: a word leaves the FIFO only on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values. The serial side cannot be stalled, so a word that arrives at a full FIFO is lost and the loss is flagged.

Three interrupt sources tell the host when to read. The first is a half-full level. The second is a sticky overrun flag. The third is a sticky timeout that fires when a word has sat unread for 32 bit periods. The bit period for the timeout comes from a prescaler on the system clock, so the timeout still expires after the master has stopped toggling the clock. Each raw source is gated by a mask register, and the sticky ones are cleared by writing ones.

The serial format is clock polarity 1, phase 0, most significant bit first. The system clock must run at least eight times the bit rate.

Top module: `spi_slave_rx`

## Requirements
- R1: Data is sampled on each falling edge of `spi_sclk` while `spi_cs_n` is low. Bits are shifted most significant first, and each run of 16 samples forms one word.
- R2: When `spi_cs_n` goes high, any partly received word is thrown away, and the next frame starts again from bit 15.
- R3: The FIFO holds 8 words and returns them oldest first. A word is removed only when `rd_valid && rd_ready`. While `rd_valid` is high and `rd_ready` is low, `rd_data` stays stable.
- R4: `rx_not_empty` is 1 whenever the FIFO holds at least one word and 0 once it has been drained.
- R5: Raw interrupt bit 0 (half) is 1 exactly while the FIFO holds 4 or more words. It is not sticky, and writing to the clear register has no effect on it.
- R6: A word that completes while the FIFO is full, with no read on the same cycle, is dropped. The stored words are left untouched, and raw bit 2 (overrun) sets and stays set.
- R7: Raw bit 1 (timeout) sets 32 × `tick_div` system-clock cycles after a word enters an empty FIFO, provided the FIFO has not been drained in the meantime. It does so even when `spi_sclk` is idle.
- R8: Reading the FIFO down to empty stops the timeout. Any new word that arrives while the timeout is running restarts the full 32-period count.
- R9: Writing 1 to a bit of `clr_wdata` (with `clr_we`) clears raw bits 1 and 2. Writing 0 leaves them unchanged.
- R10: `irq_masked` equals the raw bits ANDed with the mask register, which is loaded by `mask_we`. `irq` is the OR of `irq_masked`.
- R11: After reset, the FIFO is empty, all raw and masked bits are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| tick_div | input | 16 | System cycles per timeout bit period (0 is treated as 1) |
| rd_valid | output | 1 | FIFO head word available |
| rd_ready | input | 1 | Host accepts the head word |
| rd_data | output | 16 | FIFO head word |
| rx_not_empty | output | 1 | FIFO holds at least one word |
| mask_we | input | 1 | Load the interrupt mask |
| mask_wdata | input | 3 | New mask value |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_wdata | input | 3 | Bits to clear |
| irq_raw | output | 3 | {overrun, timeout, half} before masking |
| irq_masked | output | 3 | Raw bits ANDed with mask |
| irq | output | 1 | OR of masked bits |

## Verification
The timeout-start logic and the FIFO drain logic can act in the same cycle. A second word can land while the first is still waiting, and the host can empty the queue just before the limit. The bench provokes the first case by clocking in a second word partway through the first word's timeout window. It then checks that the timeout bit is still clear after the original deadline has passed, and that it sets only after the restarted window ends. It provokes the second case by reading every word as soon as it appears and checking that no timeout follows.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int IRQ_N    = 3;
  localparam int IRQ_HALF = 0;
  localparam int IRQ_TMO  = 1;
  localparam int IRQ_OVR  = 2;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic data_in,
  output logic sample,
  output logic sel_active,
  output logic sel_drop,
  output logic data_bit
);
  logic [STAGES-1:0] sclk_q, csn_q, data_q;
  logic sclk_prev, csn_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '1;
      csn_q     <= '1;
      data_q    <= '0;
      sclk_prev <= 1'b1;
      csn_prev  <= 1'b1;
    end else begin
      sclk_q    <= {sclk_q[STAGES-2:0], sclk_in};
      csn_q     <= {csn_q[STAGES-2:0], csn_in};
      data_q    <= {data_q[STAGES-2:0], data_in};
      sclk_prev <= sclk_q[STAGES-1];
      csn_prev  <= csn_q[STAGES-1];
    end
  end

  assign sel_active = ~csn_q[STAGES-1];
  assign sel_drop   = csn_q[STAGES-1] & ~csn_prev;
  assign sample     = sclk_prev & ~sclk_q[STAGES-1] & sel_active;
  assign data_bit   = data_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         sel_active,
  input  logic         data_bit,
  output logic         word_valid,
  output logic [W-1:0] word
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!sel_active) begin
        bit_cnt <= '0;
      end else if (sample) begin
        shreg <= {shreg[W-2:0], data_bit};
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          word       <= {shreg[W-2:0], data_bit};
          word_valid <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_word_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(sel_active));
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       accepted,
  output logic                       dropped
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_pop;

  assign full     = (level == LW'(DEPTH));
  assign do_pop   = pop && (level != '0);
  assign accepted = push && (!full || do_pop);
  assign dropped  = push && full && !do_pop;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accepted) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)   rd_ptr <= rd_ptr + 1'b1;
      if (accepted && !do_pop)      level <= level + 1'b1;
      else if (!accepted && do_pop) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= push_data;
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (level == $past(level)));
endmodule

// File: rtl/spi_rx_timeout.sv
module spi_rx_timeout #(
  parameter int BITS  = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             word_in,
  input  logic             drained,
  input  logic             fifo_empty,
  output logic             expire
);
  localparam int BW = $clog2(BITS);
  localparam logic [BW-1:0] LAST = BW'(BITS - 1);

  logic [DIV_W-1:0] pre_cnt, lim;
  logic [BW-1:0]    bit_cnt;
  logic             running, tick;

  assign lim    = (tick_div == '0) ? '0 : tick_div - 1'b1;
  assign tick   = running && (pre_cnt == lim);
  assign expire = tick && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_cnt <= '0;
      bit_cnt <= '0;
    end else if (word_in) begin
      running <= 1'b1;
      pre_cnt <= '0;
      bit_cnt <= '0;
    end else if (drained || expire) begin
      running <= 1'b0;
      pre_cnt <= '0;
      bit_cnt <= '0;
    end else if (running) begin
      if (tick) begin
        pre_cnt <= '0;
        bit_cnt <= bit_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assert_expire_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !fifo_empty);
  assert_drain_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && !word_in) |=> !expire);
endmodule

// File: rtl/spi_slave_rx.sv
module spi_slave_rx
  import spi_rx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 8,
  parameter int TMO_BITS = 32,
  parameter int DIV_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [DIV_W-1:0]  tick_div,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_not_empty,
  input  logic              mask_we,
  input  logic [IRQ_N-1:0]  mask_wdata,
  input  logic              clr_we,
  input  logic [IRQ_N-1:0]  clr_wdata,
  output logic [IRQ_N-1:0]  irq_raw,
  output logic [IRQ_N-1:0]  irq_masked,
  output logic              irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic              sample, sel_active, sel_drop, data_bit;
  logic              word_valid, accepted, dropped, expire, drained, pop;
  logic [WORD_W-1:0] word;
  logic [LW-1:0]     level;
  logic              raw_tmo, raw_ovr;
  logic [IRQ_N-1:0]  mask_q, clr_hit;

  spi_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(spi_sclk), .csn_in(spi_cs_n),
    .data_in(spi_mosi), .sample(sample), .sel_active(sel_active),
    .sel_drop(sel_drop), .data_bit(data_bit));

  spi_rx_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sample(sample), .sel_active(sel_active),
    .data_bit(data_bit), .word_valid(word_valid), .word(word));

  assign pop = rd_valid && rd_ready;

  spi_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(word_valid), .push_data(word),
    .pop(pop), .head(rd_data), .level(level), .accepted(accepted),
    .dropped(dropped));

  assign drained = pop && (level == LW'(1)) && !accepted;

  spi_rx_timeout #(.BITS(TMO_BITS), .DIV_W(DIV_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .word_in(accepted),
    .drained(drained), .fifo_empty(level == '0), .expire(expire));

  assign rd_valid     = (level != '0);
  assign rx_not_empty = rd_valid;
  assign clr_hit      = clr_we ? clr_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_tmo <= 1'b0;
      raw_ovr <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (expire)                 raw_tmo <= 1'b1;
      else if (clr_hit[IRQ_TMO])  raw_tmo <= 1'b0;
      if (dropped)                raw_ovr <= 1'b1;
      else if (clr_hit[IRQ_OVR])  raw_ovr <= 1'b0;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  always_comb begin
    irq_raw           = '0;
    irq_raw[IRQ_HALF] = (level >= LW'(DEPTH / 2));
    irq_raw[IRQ_TMO]  = raw_tmo;
    irq_raw[IRQ_OVR]  = raw_ovr;
  end

  assign irq_masked = irq_raw & mask_q;
  assign irq        = |irq_masked;

  assert_hold_under_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_ovr && !clr_hit[IRQ_OVR]) |=> raw_ovr);
  assert_abort_no_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_drop |=> !word_valid);
endmodule

// File: tb/tb_spi_slave_rx.sv
module tb_spi_slave_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [15:0] tick_div = 16'd16;
  logic        rd_valid, rd_ready = 1'b0, rx_not_empty, irq;
  logic [15:0] rd_data;
  logic        mask_we = 1'b0, clr_we = 1'b0;
  logic [2:0]  mask_wdata = '0, clr_wdata = '0, irq_raw, irq_masked;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;
  always @(negedge clk) cyc++;

  spi_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .tick_div(tick_div), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rx_not_empty(rx_not_empty),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .irq_raw(irq_raw), .irq_masked(irq_masked),
    .irq(irq));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compares each handshake against the queue (R3).
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected word", rd_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R3/R1 data order", rd_data, e);
      end
    end
  end

  // Driver: one mode-2 frame, MSB first; keep=1 queues the word as expected.
  task automatic send_word(input logic [15:0] w, input bit keep);
    if (keep) exp_q.push_back(w);
    spi_cs_n = 1'b0;
    wait_clk(8);
    for (int i = 15; i >= 0; i--) begin
      spi_mosi = w[i];
      wait_clk(8);
      spi_sclk = 1'b0;
      wait_clk(8);
      spi_sclk = 1'b1;
    end
    wait_clk(8);
    spi_cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_wdata = 3'b111;
    wait_clk(1);
    clr_we = 1'b0; clr_wdata = '0;
    wait_clk(1);
  endtask

  task automatic drain();
    rd_ready = 1'b1;
    wait_clk(20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    report();
  end

  initial begin
    int e1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    @(negedge clk);
    // R11 reset state
    check(rd_valid == 0, "R11 rd_valid", rd_valid, 0);
    check(irq_raw == 0, "R11 irq_raw", irq_raw, 0);
    check(irq == 0 && irq_masked == 0, "R11 irq", irq, 0);
    wait_clk(1);

    // R1 basic words with host always ready
    rd_ready = 1'b1;
    send_word(16'h8001, 1);
    send_word(16'h7FFE, 1);
    send_word(16'h1234, 1);
    wait_clk(10);
    check(exp_q.size() == 0, "R1 all words seen", exp_q.size(), 0);

    // R2 aborted frame: 5 bits then select released
    spi_cs_n = 1'b0; wait_clk(8);
    for (int i = 0; i < 5; i++) begin
      spi_mosi = 1'b1; wait_clk(8); spi_sclk = 1'b0; wait_clk(8); spi_sclk = 1'b1;
    end
    wait_clk(8); spi_cs_n = 1'b1; wait_clk(16);
    @(negedge clk);
    check(rd_valid == 0, "R2 partial frame discarded", rd_valid, 0);
    send_word(16'hA5C3, 1);
    wait_clk(10);
    check(exp_q.size() == 0, "R2 next frame aligned", exp_q.size(), 0);

    // R3/R4 back-pressure and not-empty
    rd_ready = 1'b0;
    send_word(16'hBEEF, 1);
    send_word(16'h0F0F, 1);
    @(negedge clk);
    check(rx_not_empty == 1, "R4 not empty set", rx_not_empty, 1);
    check(rd_data == 16'hBEEF, "R3 head held", rd_data, 16'hBEEF);
    wait_clk(30);
    @(negedge clk);
    check(rd_data == 16'hBEEF && rd_valid, "R3 head stable", rd_data, 16'hBEEF);
    drain();
    @(negedge clk);
    check(rx_not_empty == 0, "R4 not empty cleared", rx_not_empty, 1'b0);

    // R5 half-full
    tick_div = 16'd2000;
    rd_ready = 1'b0;
    for (int i = 0; i < 3; i++) send_word(16'h1000 + 16'(i), 1);
    @(negedge clk);
    check(irq_raw[0] == 0, "R5 half at 3", irq_raw[0], 0);
    send_word(16'h1003, 1);
    @(negedge clk);
    check(irq_raw[0] == 1, "R5 half at 4", irq_raw[0], 1);
    clear_all();
    @(negedge clk);
    check(irq_raw[0] == 1, "R5 half unaffected by clear", irq_raw[0], 1);
    drain();
    @(negedge clk);
    check(irq_raw[0] == 0, "R5 half drops when drained", irq_raw[0], 0);

    // R6 overrun: 8 kept, 9th dropped
    rd_ready = 1'b0;
    for (int i = 0; i < 8; i++) send_word(16'h2000 + 16'(i), 1);
    @(negedge clk);
    check(irq_raw[2] == 0, "R6 no overrun at full", irq_raw[2], 0);
    send_word(16'hDEAD, 0);
    @(negedge clk);
    check(irq_raw[2] == 1, "R6 overrun set", irq_raw[2], 1);
    wait_clk(40);
    @(negedge clk);
    check(irq_raw[2] == 1, "R6 overrun sticky", irq_raw[2], 1);
    drain();
    check(exp_q.size() == 0, "R6 stored words intact", exp_q.size(), 0);
    clr_we = 1'b1; clr_wdata = 3'b011; wait_clk(1); clr_we = 1'b0; clr_wdata = '0;
    @(negedge clk);
    check(irq_raw[2] == 1, "R9 zero bit leaves overrun", irq_raw[2], 1);
    clear_all();
    @(negedge clk);
    check(irq_raw[2] == 0, "R9 overrun cleared", irq_raw[2], 0);

    // R7 timeout with idle clock, tick_div = 16 -> 512 cycles
    tick_div = 16'd16;
    rd_ready = 1'b0;
    fork send_word(16'h3333, 1); join_none
    @(negedge clk);
    while (!rx_not_empty) @(negedge clk);
    repeat (32 * 16 - 2) @(negedge clk);
    check(irq_raw[1] == 0, "R7 timeout not early", irq_raw[1], 0);
    repeat (4) @(negedge clk);
    check(irq_raw[1] == 1, "R7 timeout fired", irq_raw[1], 1);
    wait fork;

    // R10 masking
    mask_we = 1'b1; mask_wdata = 3'b010; wait_clk(1); mask_we = 1'b0;
    @(negedge clk);
    check(irq == 1 && irq_masked == 3'b010, "R10 masked timeout", irq_masked, 3'b010);
    mask_we = 1'b1; mask_wdata = 3'b101; wait_clk(1); mask_we = 1'b0;
    @(negedge clk);
    check(irq == 0, "R10 masked off", irq, 0);
    clear_all();
    @(negedge clk);
    check(irq_raw[1] == 0, "R9 timeout cleared", irq_raw[1], 0);
    drain();

    // R8 immediate drain -> no timeout
    rd_ready = 1'b1;
    send_word(16'h4444, 1);
    wait_clk(32 * 16 + 60);
    @(negedge clk);
    check(irq_raw[1] == 0, "R8 drain stops timeout", irq_raw[1], 0);

    // R8 restart: second word during running window
    rd_ready = 1'b0;
    fork send_word(16'h5555, 1); join_none
    @(negedge clk);
    while (!rx_not_empty) @(negedge clk);
    e1 = cyc;
    wait fork;
    send_word(16'h6666, 1);
    while (cyc < e1 + 600) @(negedge clk);
    check(irq_raw[1] == 0, "R8 restart delays timeout", irq_raw[1], 0);
    while (cyc < e1 + 860) @(negedge clk);
    check(irq_raw[1] == 1, "R8 restarted timeout fires", irq_raw[1], 1);
    drain();
    check(exp_q.size() == 0, "R3 queue empty at end", exp_q.size(), 0);
    report();
  end
endmodule